// File: doc/BRIEF.md
# Linear Packet Instruction Pipeline

This block is a chain of identical processing stages that a per-packet execution context walks through, one stage per clock. The context carries a header window of the packet's leading bytes, a file of sixteen 8-bit general registers, an 8-bit offset register, four condition flags and a program-select field. Each stage owns a small local instruction store. It reads one instruction word from that store, indexed by the context's program-select field. It applies the whole word to the context in the single cycle the context spends there, then passes the result to the next stage. Nothing is fetched from a shared store at run time, and the chain never stalls or pushes back on its input.

An instruction word holds four 20-bit operation slots. All four slots read the context as it entered the stage. Their results merge into the outgoing context, and a higher-numbered slot overrides a lower one. The header window is reached only indirectly, through the offset register plus an immediate. The program is placed by writing word k of a sequence into stage k through a load port, which is used while no context is in flight. Different packet types run different sequences through the same stages by carrying a different program-select value, which is set when the context enters.

Top module: `pkt_pipe`

## Requirements
- R1: A context presented with `in_valid` high appears on the outputs with `out_valid` high exactly N_STAGES cycles later. A new context may enter on every cycle. A cycle with `in_valid` low yields `out_valid` low N_STAGES cycles later.
- R2: Slot i occupies word bits [20*i+19 : 20*i] as {opcode[3:0], dst[3:0], srcA[3:0], srcB/imm[7:0]}. Opcodes 1 to 5 write dst with rA+rB, rA-rB, rA&rB, rA|rB and rA^rB (8-bit wrap, rB indexed by imm[3:0]). Opcode 6 writes dst with imm.
- R3: Opcode 7 loads register dst from header byte (off+imm) mod HDR_BYTES. Opcode 8 stores rA to header byte (off+imm) mod HDR_BYTES. The sum off+imm wraps at 8 bits.
- R4: Opcode 9 sets the offset register to rA+imm.
- R5: Every slot reads registers, flags, offset and header as they were when the context entered the stage, whatever the other slots of the same word write.
- R6: When several live slots of one word write the same register, header byte, flag or the offset, the highest-numbered slot's value is kept.
- R7: Opcode 11 sets flag dst[1:0] to (rA == rB). Opcode 10 tests flag dst[1:0] on entry; if that flag is 1, every higher-numbered slot of the same word has no effect.
- R8: Each stage executes the word stored at its own index for the context's program select. The program-select field leaves the pipeline unchanged.
- R9: While `rst_n` is low, `out_valid` is low, and after reset every instruction store holds NOP words.
- R10: A load-port write of (stage, program, word) changes the instruction that stage applies to later contexts of that program only. Loads are issued only while no valid context is inside the pipeline.
- R11: Opcode 0 and opcodes 12 to 15 leave the context unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Context present at the head this cycle |
| in_prog | input | 2 | Program select of the entering context |
| in_off | input | 8 | Offset register of the entering context |
| in_flags | input | 4 | Condition flags of the entering context |
| in_regs | input | 128 | Register file, register r at bits [8r+7:8r] |
| in_hdr | input | 128 | Header window, byte b at bits [8b+7:8b] |
| ld_we | input | 1 | Instruction store write enable |
| ld_stage | input | 2 | Stage index of the write |
| ld_prog | input | 2 | Program select of the write |
| ld_word | input | 80 | Instruction word to store |
| out_valid | output | 1 | Finished context present at the tail |
| out_prog | output | 2 | Program select of the finished context |
| out_off | output | 8 | Offset register of the finished context |
| out_flags | output | 4 | Condition flags of the finished context |
| out_regs | output | 128 | Register file of the finished context |
| out_hdr | output | 128 | Header window of the finished context |

## Verification
The hardest case to reach from the ports is a single word whose slots interfere with each other. Such a word has slots that write a register another slot reads, duplicate destinations, and a skip whose flag was set by an earlier stage of the same packet. Random words rarely line these up, so directed sequences are loaded first. In those sequences an earlier stage sets a flag that a later stage's skip tests, and an offset set in one stage steers a wrapped load and two colliding stores in the next. A constrained random phase follows. It fills every store with random words and streams random contexts with gaps and back-to-back runs, all compared against a bench model that applies the words in order.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int DW        = 8;
    localparam int HDR_BYTES = 16;
    localparam int NREGS     = 16;
    localparam int NFLAGS    = 4;
    localparam int PSEL_W    = 2;
    localparam int NPROG     = 1 << PSEL_W;
    localparam int NSLOTS    = 4;
    localparam int SLOT_W    = 20;
    localparam int INSTR_W   = NSLOTS * SLOT_W;
    localparam int HIDX_W    = $clog2(HDR_BYTES);
    localparam int RIDX_W    = $clog2(NREGS);
    localparam int FIDX_W    = $clog2(NFLAGS);

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_ADD    = 4'd1,
        OP_SUB    = 4'd2,
        OP_AND    = 4'd3,
        OP_OR     = 4'd4,
        OP_XOR    = 4'd5,
        OP_MOVI   = 4'd6,
        OP_LOADB  = 4'd7,
        OP_STOREB = 4'd8,
        OP_SETOFF = 4'd9,
        OP_SKIPF  = 4'd10,
        OP_CMPEQ  = 4'd11
    } op_e;

    typedef struct packed {
        logic [3:0]    op;
        logic [3:0]    dst;
        logic [3:0]    srca;
        logic [DW-1:0] imm;
    } slot_t;

    typedef struct packed {
        logic [PSEL_W-1:0]               psel;
        logic [DW-1:0]                   off;
        logic [NFLAGS-1:0]               flags;
        logic [NREGS-1:0][DW-1:0]        regs;
        logic [HDR_BYTES-1:0][DW-1:0]    hdr;
    } ctx_t;

    typedef struct packed {
        logic              reg_we;
        logic [RIDX_W-1:0] reg_idx;
        logic [DW-1:0]     reg_val;
        logic              flag_we;
        logic [FIDX_W-1:0] flag_idx;
        logic              flag_val;
        logic              off_we;
        logic [DW-1:0]     off_val;
        logic              hdr_we;
        logic [HIDX_W-1:0] hdr_idx;
        logic [DW-1:0]     hdr_val;
        logic              skip;
    } eff_t;

endpackage

// File: rtl/pp_slot.sv
module pp_slot
    import pp_pkg::*;
(
    input  ctx_t  ctx_in,
    input  slot_t slot,
    output eff_t  eff
);

    logic [DW-1:0] ra;
    logic [DW-1:0] rb;
    logic [DW-1:0] addr;

    always_comb begin
        ra   = ctx_in.regs[slot.srca[RIDX_W-1:0]];
        rb   = ctx_in.regs[slot.imm[RIDX_W-1:0]];
        addr = ctx_in.off + slot.imm;
        eff  = '0;
        eff.reg_idx  = slot.dst[RIDX_W-1:0];
        eff.flag_idx = slot.dst[FIDX_W-1:0];
        eff.hdr_idx  = addr[HIDX_W-1:0];
        case (slot.op)
            OP_ADD:    begin eff.reg_we = 1'b1; eff.reg_val = ra + rb; end
            OP_SUB:    begin eff.reg_we = 1'b1; eff.reg_val = ra - rb; end
            OP_AND:    begin eff.reg_we = 1'b1; eff.reg_val = ra & rb; end
            OP_OR:     begin eff.reg_we = 1'b1; eff.reg_val = ra | rb; end
            OP_XOR:    begin eff.reg_we = 1'b1; eff.reg_val = ra ^ rb; end
            OP_MOVI:   begin eff.reg_we = 1'b1; eff.reg_val = slot.imm; end
            OP_LOADB:  begin
                eff.reg_we  = 1'b1;
                eff.reg_val = ctx_in.hdr[addr[HIDX_W-1:0]];
            end
            OP_STOREB: begin eff.hdr_we = 1'b1; eff.hdr_val = ra; end
            OP_SETOFF: begin eff.off_we = 1'b1; eff.off_val = ra + slot.imm; end
            OP_SKIPF:  eff.skip = ctx_in.flags[slot.dst[FIDX_W-1:0]];
            OP_CMPEQ:  begin eff.flag_we = 1'b1; eff.flag_val = (ra == rb); end
            default:   eff = eff;
        endcase
    end

endmodule

// File: rtl/pp_stage.sv
module pp_stage
    import pp_pkg::*;
#(
    parameter int STAGE_IDX = 0,
    parameter int SW        = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  ctx_t               in_ctx,
    input  logic               ld_we,
    input  logic [SW-1:0]      ld_stage,
    input  logic [PSEL_W-1:0]  ld_psel,
    input  logic [INSTR_W-1:0] ld_word,
    output logic               out_valid,
    output ctx_t               out_ctx
);

    localparam logic [SW-1:0] MY_IDX = SW'(STAGE_IDX);

    logic [INSTR_W-1:0] imem [NPROG];
    logic [INSTR_W-1:0] word;
    eff_t               eff [NSLOTS];
    ctx_t               nxt;
    logic               live;

    // local instruction store, one word per program select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPROG; p++) imem[p] <= '0;
        end else if (ld_we && ld_stage == MY_IDX) begin
            imem[ld_psel] <= ld_word;
        end
    end

    assign word = imem[in_ctx.psel];

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        pp_slot u_slot (
            .ctx_in (in_ctx),
            .slot   (slot_t'(word[i*SLOT_W +: SLOT_W])),
            .eff    (eff[i])
        );
    end

    // merge slot effects in ascending order: later slots override
    always_comb begin
        nxt  = in_ctx;
        live = 1'b1;
        for (int i = 0; i < NSLOTS; i++) begin
            if (live) begin
                if (eff[i].reg_we)  nxt.regs[eff[i].reg_idx]   = eff[i].reg_val;
                if (eff[i].flag_we) nxt.flags[eff[i].flag_idx] = eff[i].flag_val;
                if (eff[i].off_we)  nxt.off                    = eff[i].off_val;
                if (eff[i].hdr_we)  nxt.hdr[eff[i].hdr_idx]    = eff[i].hdr_val;
                if (eff[i].skip)    live = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ctx   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_ctx <= nxt;
        end
    end

endmodule

// File: rtl/pkt_pipe.sv
module pkt_pipe
    import pp_pkg::*;
#(
    parameter int N_STAGES = 4,
    localparam int SW      = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [PSEL_W-1:0]       in_prog,
    input  logic [DW-1:0]           in_off,
    input  logic [NFLAGS-1:0]       in_flags,
    input  logic [NREGS*DW-1:0]     in_regs,
    input  logic [HDR_BYTES*DW-1:0] in_hdr,
    input  logic                    ld_we,
    input  logic [SW-1:0]           ld_stage,
    input  logic [PSEL_W-1:0]       ld_prog,
    input  logic [INSTR_W-1:0]      ld_word,
    output logic                    out_valid,
    output logic [PSEL_W-1:0]       out_prog,
    output logic [DW-1:0]           out_off,
    output logic [NFLAGS-1:0]       out_flags,
    output logic [NREGS*DW-1:0]     out_regs,
    output logic [HDR_BYTES*DW-1:0] out_hdr
);

    ctx_t                             head_ctx;
    ctx_t                             stage_ctx [N_STAGES];
    logic [N_STAGES-1:0]              stage_v;
    logic [N_STAGES-1:0][PSEL_W-1:0]  stage_psel;

    always_comb begin
        head_ctx.psel  = in_prog;
        head_ctx.off   = in_off;
        head_ctx.flags = in_flags;
        head_ctx.regs  = in_regs;
        head_ctx.hdr   = in_hdr;
    end

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            pp_stage #(.STAGE_IDX(k), .SW(SW)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (in_valid),
                .in_ctx    (head_ctx),
                .ld_we     (ld_we),
                .ld_stage  (ld_stage),
                .ld_psel   (ld_prog),
                .ld_word   (ld_word),
                .out_valid (stage_v[k]),
                .out_ctx   (stage_ctx[k])
            );
        end else begin : g_body
            pp_stage #(.STAGE_IDX(k), .SW(SW)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (stage_v[k-1]),
                .in_ctx    (stage_ctx[k-1]),
                .ld_we     (ld_we),
                .ld_stage  (ld_stage),
                .ld_psel   (ld_prog),
                .ld_word   (ld_word),
                .out_valid (stage_v[k]),
                .out_ctx   (stage_ctx[k])
            );
        end
        assign stage_psel[k] = stage_ctx[k].psel;
    end

    assign out_valid = stage_v[N_STAGES-1];
    assign out_prog  = stage_ctx[N_STAGES-1].psel;
    assign out_off   = stage_ctx[N_STAGES-1].off;
    assign out_flags = stage_ctx[N_STAGES-1].flags;
    assign out_regs  = stage_ctx[N_STAGES-1].regs;
    assign out_hdr   = stage_ctx[N_STAGES-1].hdr;

endmodule

// File: rtl/pp_chk.sv
module pp_chk
    import pp_pkg::*;
#(
    parameter int N_STAGES = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            in_valid,
    input logic [PSEL_W-1:0]               in_prog,
    input logic                            ld_we,
    input logic [N_STAGES-1:0]             stage_v,
    input logic [N_STAGES-1:0][PSEL_W-1:0] stage_psel
);

    // R1: the head stage captures the entry valid every cycle
    a_r1_head_entry: assert property (@(posedge clk) disable iff (!rst_n)
        stage_v[0] == $past(in_valid));

    // R8: program select is captured unchanged at the head
    a_r8_head_psel: assert property (@(posedge clk) disable iff (!rst_n)
        stage_v[0] |-> stage_psel[0] == $past(in_prog));

    for (genvar k = 1; k < N_STAGES; k++) begin : g_adv
        // R1: every context advances one stage per clock, no stall
        a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
            stage_v[k] == $past(stage_v[k-1]));
        // R8: program select travels with its context
        a_r8_psel_kept: assert property (@(posedge clk) disable iff (!rst_n)
            stage_v[k] |-> stage_psel[k] == $past(stage_psel[k-1]));
    end

    // R10: loads only while nothing is in flight
    a_r10_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> (stage_v == '0 && !in_valid));

    // R9: the chain is empty on the first cycle out of reset
    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> stage_v == '0);

endmodule

bind pkt_pipe pp_chk #(.N_STAGES(N_STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_prog    (in_prog),
    .ld_we      (ld_we),
    .stage_v    (stage_v),
    .stage_psel (stage_psel)
);

// File: tb/sim_pkt_pipe.sv
module sim_pkt_pipe;
    import pp_pkg::*;

    localparam int N  = 4;
    localparam int SW = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [PSEL_W-1:0]       in_prog = '0;
    logic [DW-1:0]           in_off = '0;
    logic [NFLAGS-1:0]       in_flags = '0;
    logic [NREGS*DW-1:0]     in_regs = '0;
    logic [HDR_BYTES*DW-1:0] in_hdr = '0;
    logic                    ld_we = 1'b0;
    logic [SW-1:0]           ld_stage = '0;
    logic [PSEL_W-1:0]       ld_prog = '0;
    logic [INSTR_W-1:0]      ld_word = '0;
    logic                    out_valid;
    logic [PSEL_W-1:0]       out_prog;
    logic [DW-1:0]           out_off;
    logic [NFLAGS-1:0]       out_flags;
    logic [NREGS*DW-1:0]     out_regs;
    logic [HDR_BYTES*DW-1:0] out_hdr;

    pkt_pipe #(.N_STAGES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prog(in_prog),
        .in_off(in_off), .in_flags(in_flags), .in_regs(in_regs), .in_hdr(in_hdr),
        .ld_we(ld_we), .ld_stage(ld_stage), .ld_prog(ld_prog), .ld_word(ld_word),
        .out_valid(out_valid), .out_prog(out_prog), .out_off(out_off),
        .out_flags(out_flags), .out_regs(out_regs), .out_hdr(out_hdr)
    );

    always #10 clk = ~clk;

    int unsigned        cyc = 0;
    int                 checks = 0;
    int                 errors = 0;
    bit                 mon_on = 1'b0;
    bit                 done = 1'b0;
    string              cur_req = "R2";
    logic [INSTR_W-1:0] imem_m [N][NPROG];
    bit                 exp_v [64];
    ctx_t               exp_c [64];
    ctx_t               last_o;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [1023:0] act, logic [1023:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [SLOT_W-1:0] sl(int op, int d, int a, int imm);
        return {4'(op), 4'(d), 4'(a), 8'(imm)};
    endfunction

    function automatic ctx_t ref_word(ctx_t c, logic [INSTR_W-1:0] w);
        ctx_t r = c;
        bit   live = 1'b1;
        for (int s = 0; s < NSLOTS; s++) begin
            slot_t   q = slot_t'(w[s*SLOT_W +: SLOT_W]);
            logic [7:0] a = c.regs[q.srca];
            logic [7:0] b = c.regs[q.imm[3:0]];
            int      ad = (int'(c.off) + int'(q.imm)) % HDR_BYTES;
            if (live) begin
                case (int'(q.op))
                    1:  r.regs[q.dst] = a + b;
                    2:  r.regs[q.dst] = a - b;
                    3:  r.regs[q.dst] = a & b;
                    4:  r.regs[q.dst] = a | b;
                    5:  r.regs[q.dst] = a ^ b;
                    6:  r.regs[q.dst] = q.imm;
                    7:  r.regs[q.dst] = c.hdr[ad];
                    8:  r.hdr[ad] = a;
                    9:  r.off = a + q.imm;
                    10: if (c.flags[q.dst[1:0]]) live = 1'b0;
                    11: r.flags[q.dst[1:0]] = (a == b);
                    default: ;
                endcase
            end
        end
        return r;
    endfunction

    function automatic ctx_t ref_pipe(ctx_t c);
        ctx_t r = c;
        for (int k = 0; k < N; k++) r = ref_word(r, imem_m[k][r.psel]);
        return r;
    endfunction

    function automatic ctx_t rand_ctx(int prog);
        ctx_t c;
        c.psel  = 2'(prog);
        c.off   = 8'($urandom);
        c.flags = 4'($urandom);
        for (int i = 0; i < NREGS; i++) c.regs[i] = 8'($urandom);
        for (int i = 0; i < HDR_BYTES; i++) c.hdr[i] = 8'($urandom);
        return c;
    endfunction

    task automatic drive(bit v, ctx_t c);
        @(negedge clk);
        in_valid = v;
        in_prog  = c.psel;
        in_off   = c.off;
        in_flags = c.flags;
        in_regs  = c.regs;
        in_hdr   = c.hdr;
        exp_v[(cyc + N) % 64] = v;
        if (v) exp_c[(cyc + N) % 64] = ref_pipe(c);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic load(int st, int pg, logic [INSTR_W-1:0] w);
        @(negedge clk);
        in_valid = 1'b0;
        ld_we    = 1'b1;
        ld_stage = SW'(st);
        ld_prog  = 2'(pg);
        ld_word  = w;
        imem_m[st][pg] = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // output monitor: valid timing (R1) and full context vs. model
    always @(negedge clk) begin
        if (mon_on) begin
            int   ix;
            ctx_t o;
            ix = int'(cyc % 64);
            o.psel = out_prog; o.off = out_off; o.flags = out_flags;
            o.regs = out_regs; o.hdr = out_hdr;
            check(out_valid === exp_v[ix], "R1", "out_valid timing", 1024'(out_valid), 1024'(exp_v[ix]));
            if (exp_v[ix] && out_valid) begin
                check(o === exp_c[ix], cur_req, "context", 1024'(o), 1024'(exp_c[ix]));
                last_o = o;
            end
            exp_v[ix] = 1'b0;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        ctx_t c;
        void'($urandom(32'd20240611));
        for (int k = 0; k < N; k++)
            for (int p = 0; p < NPROG; p++) imem_m[k][p] = '0;
        for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;

        // R9: output idle during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", "out_valid in reset", 1024'(out_valid), 1024'(0));
        end
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R9/R11: stores reset to NOP, so context passes unchanged
        cur_req = "R9";
        c = rand_ctx(2);
        drive(1'b1, c);
        idle(N + 1);
        check(last_o === c, "R9", "NOP after reset", 1024'(last_o), 1024'(c));

        // directed program 1: R5 R6 R2 in stage 0/1, R4 R3 in stage 2/3
        load(0, 1, {sl(6, 3, 0, 9), sl(6, 3, 0, 7), sl(1, 2, 1, 1), sl(6, 1, 0, 5)});
        load(1, 1, {sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(2, 4, 1, 2)});
        load(2, 1, {sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(9, 0, 0, 14)});
        load(3, 1, {sl(0, 0, 0, 0), sl(8, 0, 11, 5), sl(8, 0, 10, 5), sl(7, 9, 0, 3)});
        cur_req = "R5 R6 R3 R4";
        c = rand_ctx(1);
        c.regs[0] = 8'h00; c.regs[1] = 8'h03; c.regs[10] = 8'h10; c.regs[11] = 8'h11;
        c.hdr[1] = 8'hA1;
        drive(1'b1, c);
        idle(N + 1);
        check(last_o.regs[2] == 8'h06, "R5", "slot reads entry r1", 1024'(last_o.regs[2]), 1024'(8'h06));
        check(last_o.regs[3] == 8'h09, "R6", "higher slot wins reg", 1024'(last_o.regs[3]), 1024'(8'h09));
        check(last_o.regs[4] == 8'hFF, "R2", "SUB wraps", 1024'(last_o.regs[4]), 1024'(8'hFF));
        check(last_o.off == 8'd14, "R4", "SETOFF", 1024'(last_o.off), 1024'(14));
        check(last_o.regs[9] == 8'hA1, "R3", "LOADB wrapped index", 1024'(last_o.regs[9]), 1024'(8'hA1));
        check(last_o.hdr[3] == 8'h11, "R6", "higher slot wins store", 1024'(last_o.hdr[3]), 1024'(8'h11));

        // directed program 2: R7 flag set then skip
        load(0, 2, {sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(11, 2, 5, 6), sl(11, 1, 0, 0)});
        load(1, 2, {sl(6, 12, 0, 1), sl(6, 6, 0, 8'h11), sl(10, 1, 0, 0), sl(6, 5, 0, 8'h55)});
        load(2, 2, {sl(0, 0, 0, 0), sl(6, 8, 0, 8'h44), sl(10, 2, 0, 0), sl(6, 7, 0, 8'h33)});
        cur_req = "R7";
        c = rand_ctx(2);
        c.flags = 4'b0000;
        c.regs[5] = 8'h01; c.regs[6] = 8'h22; c.regs[12] = 8'h77;
        drive(1'b1, c);
        idle(N + 1);
        check(last_o.flags[1] == 1'b1, "R7", "CMPEQ equal", 1024'(last_o.flags[1]), 1024'(1));
        check(last_o.regs[5] == 8'h55, "R7", "slot before skip", 1024'(last_o.regs[5]), 1024'(8'h55));
        check(last_o.regs[6] == 8'h22, "R7", "skipped slot", 1024'(last_o.regs[6]), 1024'(8'h22));
        check(last_o.regs[12] == 8'h77, "R7", "skipped last slot", 1024'(last_o.regs[12]), 1024'(8'h77));
        check(last_o.regs[8] == 8'h44, "R7", "flag clear no skip", 1024'(last_o.regs[8]), 1024'(8'h44));

        // R11: opcodes 12..15 do nothing
        load(0, 3, {sl(15, 1, 2, 3), sl(14, 4, 5, 6), sl(13, 7, 8, 9), sl(12, 0, 1, 2)});
        cur_req = "R11";
        c = rand_ctx(3);
        drive(1'b1, c);
        idle(N + 1);
        check(last_o === c, "R11", "reserved opcodes", 1024'(last_o), 1024'(c));

        // R10: reload one stage/program; R8 other programs keep theirs
        load(1, 3, {sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(6, 0, 0, 8'hAA)});
        cur_req = "R10";
        c = rand_ctx(3);
        drive(1'b1, c);
        idle(N + 1);
        check(last_o.regs[0] == 8'hAA, "R10", "reloaded word", 1024'(last_o.regs[0]), 1024'(8'hAA));
        load(1, 3, {sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(0, 0, 0, 0), sl(6, 0, 0, 8'h55)});
        drive(1'b1, c);
        c.psel = 2'd0;
        drive(1'b1, c);
        idle(N + 1);
        check(last_o === c, "R8", "program 0 unaffected", 1024'(last_o), 1024'(c));

        // R1 R8: back-to-back over all programs, directed words still loaded
        cur_req = "R8";
        for (int i = 0; i < 40; i++) drive(1'b1, rand_ctx(i % NPROG));
        idle(N + 1);

        // constrained random: random words everywhere, random gaps
        for (int k = 0; k < N; k++)
            for (int p = 0; p < NPROG; p++) begin
                logic [INSTR_W-1:0] w;
                for (int s = 0; s < NSLOTS; s++)
                    w[s*SLOT_W +: SLOT_W] = sl(int'($urandom % 12), int'($urandom % 16),
                                               int'($urandom % 16), int'($urandom % 256));
                load(k, p, w);
            end
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            bit v = ($urandom % 4) != 0;
            drive(v, rand_ctx(int'($urandom % NPROG)));
        end
        idle(N + 2);
        finish_run();
    end

endmodule